// File: doc/BRIEF.md
# Standby Wake-Up Controller

This block decides what a sleep instruction does to a small processor core and controls the way back out. A sleep strobe from the core is resolved from two configuration bits into one of three low-power states. In plain halt the core stops and the oscillator keeps running. In idle the core stops, the oscillator keeps running and the address lines are parked. In standby the oscillator enable is also dropped. In every low-power state the core-run enable is low and the halt status flag is high.

Leaving standby means restarting the oscillator and letting it settle before anything is clocked. One stabilisation counter serves both the interrupt wake path and the external bus-grant path. The quick-recovery bit sets its length to either 64 cycles or 2^LONG_LOG2 cycles (2^17 by default). The counter runs only while the oscillator is enabled and restarts from zero for every accepted event. A synchronous reset skips the counter entirely, because the logic that drives reset keeps it asserted until the clock is stable. A separate register holds the clock-divide selection. Reset forces it to divide-by-two, and software can then rewrite it.

Top module: `standby_wake_ctrl`

## Requirements
- R1: After reset the block is in run: core_run=1, osc_en=1, halt_flag=0, bus_ack=0, addr_ones=0, lp_mode=0, div_one=0.
- R2: A sleep_stb sampled in run with cfg_iostop=1 and cfg_stby_sel=1 enters standby on that edge: lp_mode=3, osc_en=0, core_run=0, halt_flag=1, addr_ones=1.
- R3: A sleep_stb with cfg_iostop=1 and cfg_stby_sel=0 enters idle (lp_mode=2, osc_en=1, addr_ones=1). With cfg_iostop=0 it enters halt (lp_mode=1, osc_en=1, addr_ones=0). In both cases core_run=0.
- R4: In standby, nmi_req=1, or irq_req[i]=1 together with cfg_irq_en[i]=1, is accepted as a wake. An irq_req line whose enable bit is 0 is ignored: osc_en stays 0 and lp_mode stays 3.
- R5: On an accepted standby wake, osc_en is 1 from the acceptance edge onward. core_run rises exactly L edges after the acceptance edge, where L=64 if cfg_quick was 1 at acceptance and L=2^LONG_LOG2 otherwise.
- R6: In standby, bus_req is ignored while cfg_bus_rel_en=0. While cfg_bus_rel_en=1 it is accepted, and bus_ack rises exactly L edges later, using the same L as R5.
- R7: While the bus is granted from standby, halt_flag=1, addr_ones=1, core_run=0 and lp_mode=3. Dropping bus_req returns the block to standby (osc_en=0, bus_ack=0) on the next edge, without resuming the core.
- R8: If a wake and a standby bus request are present on the same edge, the bus request is served first. The wake is accepted on the first edge after the block returns to standby, and then takes its full stabilisation time.
- R9: In idle, bus_req is accepted and bus_ack rises 10 edges later (the 9.5-cycle grant delay rounded up). Dropping bus_req returns the block to idle.
- R10: In halt or idle, an accepted wake (defined as in R4) returns the block to run on the next edge.
- R11: rst=1 returns the block to run on the next edge from any state, with no stabilisation count, and forces div_one=0. Outside reset, cfg_div_wr=1 loads cfg_div_val into div_one on the next edge.
- R12: bus_ack stays 0 in run and halt, whatever the value of bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep_stb | input | 1 | One-cycle sleep instruction strobe from the core |
| cfg_iostop | input | 1 | I/O stop bit; 1 selects idle or standby |
| cfg_stby_sel | input | 1 | Standby select bit |
| cfg_quick | input | 1 | Quick recovery: 1 selects the 64-cycle wait |
| cfg_bus_rel_en | input | 1 | Allows a bus grant from standby |
| cfg_irq_en | input | N_IRQ | Per-line wake enable for the maskable interrupts |
| cfg_div_wr | input | 1 | Write strobe for the clock-divide bit |
| cfg_div_val | input | 1 | Value written to the clock-divide bit |
| nmi_req | input | 1 | Non-maskable interrupt request, active high |
| irq_req | input | N_IRQ | Maskable interrupt requests, active high |
| bus_req | input | 1 | External bus request, active high |
| osc_en | output | 1 | Oscillator enable |
| core_run | output | 1 | Core run enable |
| bus_ack | output | 1 | Bus acknowledge |
| halt_flag | output | 1 | Halt status |
| addr_ones | output | 1 | Address lines parked at all ones |
| lp_mode | output | 2 | 0 run, 1 halt, 2 idle, 3 standby |
| div_one | output | 1 | 1 = divide-by-one, 0 = divide-by-two |

## Verification
Mode changes from a sleep strobe, a wake in halt or idle, a bus release and a reset each appear one edge after the input is sampled, so the bench drives on the falling edge and checks after exactly one rising edge. Stabilisation results are due exactly L edges after the acceptance edge (L is 64, 2^LONG_LOG2 or 10 in idle). The bench checks them both at L-1 edges (still low) and at L edges (high), which pins the count exactly. The bench shortens LONG_LOG2 to 9 so that random sleep and wake rounds with both recovery lengths fit the run time.

// File: rtl/swk_pkg.sv
package swk_pkg;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_HALT,
        ST_IDLE,
        ST_IDLE_BWAIT,
        ST_IDLE_GRANT,
        ST_STBY,
        ST_STBY_WWAIT,
        ST_STBY_BWAIT,
        ST_STBY_GRANT
    } swk_state_e;

    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_HALT = 2'd1,
        LP_IDLE = 2'd2,
        LP_STBY = 2'd3
    } lp_mode_e;

    typedef enum logic [1:0] {
        LIM_IDLE,
        LIM_SHORT,
        LIM_LONG
    } lim_sel_e;

    // Low-power target chosen by a sleep strobe
    function automatic lp_mode_e sleep_target(input logic iostop, input logic stby_sel);
        if (!iostop)
            return LP_HALT;
        else if (stby_sel)
            return LP_STBY;
        else
            return LP_IDLE;
    endfunction

    function automatic lp_mode_e state_mode(input swk_state_e s);
        case (s)
            ST_RUN:                                       return LP_RUN;
            ST_HALT:                                      return LP_HALT;
            ST_IDLE, ST_IDLE_BWAIT, ST_IDLE_GRANT:        return LP_IDLE;
            default:                                      return LP_STBY;
        endcase
    endfunction

    function automatic logic is_wait(input swk_state_e s);
        return (s == ST_IDLE_BWAIT) || (s == ST_STBY_WWAIT) || (s == ST_STBY_BWAIT);
    endfunction

endpackage

// File: rtl/swk_event_qual.sv
module swk_event_qual #(
    parameter int N_IRQ = 3
) (
    input  logic             nmi_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             bus_req,
    input  logic             bus_rel_en,
    output logic             wake_evt,
    output logic             stby_bus_evt
);
    logic [N_IRQ-1:0] irq_hit;

    genvar g;
    generate
        for (g = 0; g < N_IRQ; g++) begin : g_irq
            assign irq_hit[g] = irq_req[g] & irq_en[g];
        end
    endgenerate

    assign wake_evt     = nmi_req | (|irq_hit);
    assign stby_bus_evt = bus_req & bus_rel_en;
endmodule

// File: rtl/swk_stab_counter.sv
module swk_stab_counter #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] last,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = en && (cnt_q == last);
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
    import swk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_stb,
    input  logic       iostop,
    input  logic       stby_sel,
    input  logic       quick,
    input  logic       wake_evt,
    input  logic       bus_req,
    input  logic       stby_bus_evt,
    input  logic       cnt_done,
    output swk_state_e state,
    output logic       cnt_clr,
    output logic       cnt_en,
    output lim_sel_e   lim_sel
);
    swk_state_e state_q, state_d;
    logic       quick_q, quick_d;

    always_comb begin
        state_d = state_q;
        quick_d = quick_q;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_stb) begin
                    unique case (sleep_target(iostop, stby_sel))
                        LP_HALT: state_d = ST_HALT;
                        LP_IDLE: state_d = ST_IDLE;
                        default: state_d = ST_STBY;
                    endcase
                end
            end
            ST_HALT: if (wake_evt) state_d = ST_RUN;
            ST_IDLE: begin
                if (bus_req) begin
                    state_d = ST_IDLE_BWAIT;
                    cnt_clr = 1'b1;
                end else if (wake_evt) begin
                    state_d = ST_RUN;
                end
            end
            ST_IDLE_BWAIT: begin
                if (!bus_req)     state_d = ST_IDLE;
                else if (cnt_done) state_d = ST_IDLE_GRANT;
            end
            ST_IDLE_GRANT: if (!bus_req) state_d = ST_IDLE;
            ST_STBY: begin
                // Bus request takes priority over a wake
                if (stby_bus_evt) begin
                    state_d = ST_STBY_BWAIT;
                    cnt_clr = 1'b1;
                    quick_d = quick;
                end else if (wake_evt) begin
                    state_d = ST_STBY_WWAIT;
                    cnt_clr = 1'b1;
                    quick_d = quick;
                end
            end
            ST_STBY_WWAIT: if (cnt_done) state_d = ST_RUN;
            ST_STBY_BWAIT: begin
                if (!bus_req)      state_d = ST_STBY;
                else if (cnt_done) state_d = ST_STBY_GRANT;
            end
            ST_STBY_GRANT: if (!bus_req) state_d = ST_STBY;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            quick_q <= 1'b0;
        end else begin
            state_q <= state_d;
            quick_q <= quick_d;
        end
    end

    assign state   = state_q;
    assign cnt_en  = is_wait(state_q);
    assign lim_sel = (state_q == ST_IDLE_BWAIT) ? LIM_IDLE :
                     (quick_q ? LIM_SHORT : LIM_LONG);
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
    import swk_pkg::*;
#(
    parameter int N_IRQ        = 3,
    parameter int LONG_LOG2    = 17,
    parameter int SHORT_WAIT   = 64,
    parameter int IDLE_ACK_CYC = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_stb,
    input  logic             cfg_iostop,
    input  logic             cfg_stby_sel,
    input  logic             cfg_quick,
    input  logic             cfg_bus_rel_en,
    input  logic [N_IRQ-1:0] cfg_irq_en,
    input  logic             cfg_div_wr,
    input  logic             cfg_div_val,
    input  logic             nmi_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             bus_req,
    output logic             osc_en,
    output logic             core_run,
    output logic             bus_ack,
    output logic             halt_flag,
    output logic             addr_ones,
    output logic [1:0]       lp_mode,
    output logic             div_one
);
    localparam int CNT_W = LONG_LOG2 + 1;
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((64'd1 << LONG_LOG2) - 64'd1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_WAIT - 1);
    localparam logic [CNT_W-1:0] IDLE_LAST  = CNT_W'(IDLE_ACK_CYC - 1);

    logic             wake_evt, stby_bus_evt;
    logic             cnt_clr, cnt_en, cnt_done;
    logic [CNT_W-1:0] cnt_last;
    swk_state_e       state;
    lim_sel_e         lim_sel;
    lp_mode_e         mode;
    logic             div_q;

    swk_event_qual #(.N_IRQ(N_IRQ)) u_qual (
        .nmi_req      (nmi_req),
        .irq_req      (irq_req),
        .irq_en       (cfg_irq_en),
        .bus_req      (bus_req),
        .bus_rel_en   (cfg_bus_rel_en),
        .wake_evt     (wake_evt),
        .stby_bus_evt (stby_bus_evt)
    );

    swk_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sleep_stb    (sleep_stb),
        .iostop       (cfg_iostop),
        .stby_sel     (cfg_stby_sel),
        .quick        (cfg_quick),
        .wake_evt     (wake_evt),
        .bus_req      (bus_req),
        .stby_bus_evt (stby_bus_evt),
        .cnt_done     (cnt_done),
        .state        (state),
        .cnt_clr      (cnt_clr),
        .cnt_en       (cnt_en),
        .lim_sel      (lim_sel)
    );

    always_comb begin
        unique case (lim_sel)
            LIM_IDLE:  cnt_last = IDLE_LAST;
            LIM_SHORT: cnt_last = SHORT_LAST;
            default:   cnt_last = LONG_LAST;
        endcase
    end

    swk_stab_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .en   (cnt_en),
        .last (cnt_last),
        .done (cnt_done)
    );

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= 1'b0;
        else if (cfg_div_wr)
            div_q <= cfg_div_val;
    end

    assign mode      = state_mode(state);
    assign lp_mode   = mode;
    assign osc_en    = (state != ST_STBY);
    assign core_run  = (state == ST_RUN);
    assign bus_ack   = (state == ST_IDLE_GRANT) || (state == ST_STBY_GRANT);
    assign halt_flag = (mode != LP_RUN);
    assign addr_ones = (mode == LP_IDLE) || (mode == LP_STBY);
    assign div_one   = div_q;
endmodule

// File: rtl/swk_checker.sv
module swk_checker #(
    parameter int N_IRQ = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             sleep_stb,
    input logic             cfg_iostop,
    input logic             cfg_stby_sel,
    input logic             cfg_bus_rel_en,
    input logic [N_IRQ-1:0] cfg_irq_en,
    input logic             cfg_div_wr,
    input logic             cfg_div_val,
    input logic             nmi_req,
    input logic [N_IRQ-1:0] irq_req,
    input logic             bus_req,
    input logic             osc_en,
    input logic             core_run,
    input logic             bus_ack,
    input logic             halt_flag,
    input logic             addr_ones,
    input logic [1:0]       lp_mode,
    input logic             div_one
);
    a_r2_enter_standby: assert property (@(posedge clk) disable iff (rst)
        (core_run && sleep_stb && cfg_iostop && cfg_stby_sel) |=> (lp_mode == 2'd3 && !osc_en && !core_run));

    a_r4_stay_asleep: assert property (@(posedge clk) disable iff (rst)
        (lp_mode == 2'd3 && !osc_en && !nmi_req && !(|(irq_req & cfg_irq_en)) && !(bus_req && cfg_bus_rel_en))
        |=> !osc_en);

    a_r7_granted_status: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && lp_mode == 2'd3) |-> (halt_flag && addr_ones && !core_run));

    a_r11_reset_wake: assert property (@(posedge clk)
        rst |=> (core_run && osc_en && !div_one));

    a_r11_div_write: assert property (@(posedge clk) disable iff (rst)
        cfg_div_wr |=> (div_one == $past(cfg_div_val)));

    a_r12_no_ack_run_halt: assert property (@(posedge clk) disable iff (rst)
        (lp_mode <= 2'd1) |-> !bus_ack);
endmodule

bind standby_wake_ctrl swk_checker #(.N_IRQ(N_IRQ)) u_swk_chk (
    .clk            (clk),
    .rst            (rst),
    .sleep_stb      (sleep_stb),
    .cfg_iostop     (cfg_iostop),
    .cfg_stby_sel   (cfg_stby_sel),
    .cfg_bus_rel_en (cfg_bus_rel_en),
    .cfg_irq_en     (cfg_irq_en),
    .cfg_div_wr     (cfg_div_wr),
    .cfg_div_val    (cfg_div_val),
    .nmi_req        (nmi_req),
    .irq_req        (irq_req),
    .bus_req        (bus_req),
    .osc_en         (osc_en),
    .core_run       (core_run),
    .bus_ack        (bus_ack),
    .halt_flag      (halt_flag),
    .addr_ones      (addr_ones),
    .lp_mode        (lp_mode),
    .div_one        (div_one)
);

// File: tb/standby_wake_ctrl_tb.sv
module standby_wake_ctrl_tb;
    localparam int N_IRQ     = 3;
    localparam int LONG_LOG2 = 9;
    localparam int LONG_LEN  = 1 << LONG_LOG2;
    localparam int SHORT_LEN = 64;
    localparam int IDLE_LEN  = 10;

    logic clk = 1'b0;
    logic rst, sleep_stb, cfg_iostop, cfg_stby_sel, cfg_quick, cfg_bus_rel_en;
    logic [N_IRQ-1:0] cfg_irq_en, irq_req;
    logic cfg_div_wr, cfg_div_val, nmi_req, bus_req;
    logic osc_en, core_run, bus_ack, halt_flag, addr_ones, div_one;
    logic [1:0] lp_mode;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    standby_wake_ctrl #(.N_IRQ(N_IRQ), .LONG_LOG2(LONG_LOG2)) u_dut (
        .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .cfg_iostop(cfg_iostop),
        .cfg_stby_sel(cfg_stby_sel), .cfg_quick(cfg_quick), .cfg_bus_rel_en(cfg_bus_rel_en),
        .cfg_irq_en(cfg_irq_en), .cfg_div_wr(cfg_div_wr), .cfg_div_val(cfg_div_val),
        .nmi_req(nmi_req), .irq_req(irq_req), .bus_req(bus_req), .osc_en(osc_en),
        .core_run(core_run), .bus_ack(bus_ack), .halt_flag(halt_flag), .addr_ones(addr_ones),
        .lp_mode(lp_mode), .div_one(div_one)
    );

    function automatic int exp_mode(input logic iostop, input logic stby);
        if (!iostop) return 1;
        return stby ? 3 : 2;
    endfunction

    function automatic int exp_len(input logic quick);
        return quick ? SHORT_LEN : LONG_LEN;
    endfunction

    task automatic check(input int actual, input int expected, input string tag);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_sleep(input logic iostop, input logic stby);
        cfg_iostop = iostop; cfg_stby_sel = stby;
        sleep_stb = 1'b1;
        tick();
        sleep_stb = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; sleep_stb = 0; cfg_iostop = 0; cfg_stby_sel = 0; cfg_quick = 1;
        cfg_bus_rel_en = 0; cfg_irq_en = '0; cfg_div_wr = 0; cfg_div_val = 0;
        nmi_req = 0; irq_req = '0; bus_req = 0;
        @(negedge clk);
        tick(2);
        rst = 0;
        tick();
        // R1 reset state
        check(core_run, 1, "R1 core_run");
        check(osc_en, 1, "R1 osc_en");
        check(halt_flag, 0, "R1 halt_flag");
        check(bus_ack, 0, "R1 bus_ack");
        check(addr_ones, 0, "R1 addr_ones");
        check(lp_mode, 0, "R1 lp_mode");
        check(div_one, 0, "R1 div_one");

        // R11 divide bit write
        cfg_div_wr = 1; cfg_div_val = 1; tick(); cfg_div_wr = 0;
        check(div_one, 1, "R11 div write");

        // R12 bus request in run ignored
        bus_req = 1; tick(3);
        check(bus_ack, 0, "R12 run bus_ack");
        bus_req = 0;

        // R3 halt, R12 bus in halt, R10 wake from halt
        do_sleep(0, 1);
        check(lp_mode, 1, "R3 halt lp_mode");
        check(osc_en, 1, "R3 halt osc_en");
        check(core_run, 0, "R3 halt core_run");
        check(addr_ones, 0, "R3 halt addr_ones");
        bus_req = 1; tick(3);
        check(bus_ack, 0, "R12 halt bus_ack");
        bus_req = 0;
        cfg_irq_en = 3'b100; irq_req = 3'b100; tick(); irq_req = '0;
        check(core_run, 1, "R10 halt wake");

        // R3 idle, R9 idle bus grant
        do_sleep(1, 0);
        check(lp_mode, 2, "R3 idle lp_mode");
        check(addr_ones, 1, "R3 idle addr_ones");
        check(osc_en, 1, "R3 idle osc_en");
        bus_req = 1; tick(); tick(IDLE_LEN - 1);
        check(bus_ack, 0, "R9 idle ack early");
        tick();
        check(bus_ack, 1, "R9 idle ack due");
        bus_req = 0; tick();
        check(bus_ack, 0, "R9 idle release");
        check(lp_mode, 2, "R9 back to idle");
        nmi_req = 1; tick(); nmi_req = 0;
        check(core_run, 1, "R10 idle wake");

        // R2 standby, R4 masked irq ignored
        do_sleep(1, 1);
        check(lp_mode, 3, "R2 lp_mode");
        check(osc_en, 0, "R2 osc_en");
        check(halt_flag, 1, "R2 halt_flag");
        check(addr_ones, 1, "R2 addr_ones");
        cfg_irq_en = 3'b010; irq_req = 3'b001; tick(5);
        check(osc_en, 0, "R4 masked irq osc_en");
        check(lp_mode, 3, "R4 masked irq lp_mode");
        // R6 bus request with release disabled ignored
        cfg_bus_rel_en = 0; bus_req = 1; tick(5);
        check(bus_ack, 0, "R6 disabled bus_ack");
        check(osc_en, 0, "R6 disabled osc_en");
        bus_req = 0; irq_req = 3'b010;
        // R4/R5 enabled irq, long wait
        cfg_quick = 0; tick(); irq_req = '0; cfg_quick = 1;
        check(osc_en, 1, "R5 osc on after accept");
        tick(LONG_LEN - 1);
        check(core_run, 0, "R5 long early");
        tick();
        check(core_run, 1, "R5 long due");

        // R6/R7 bus grant from standby, short wait
        do_sleep(1, 1);
        cfg_bus_rel_en = 1; bus_req = 1; tick(); tick(SHORT_LEN - 1);
        check(bus_ack, 0, "R6 ack early");
        tick();
        check(bus_ack, 1, "R6 ack due");
        check(halt_flag, 1, "R7 halt_flag");
        check(addr_ones, 1, "R7 addr_ones");
        check(core_run, 0, "R7 core_run");
        bus_req = 0; tick();
        check(bus_ack, 0, "R7 release ack");
        check(osc_en, 0, "R7 release osc_en");
        check(lp_mode, 3, "R7 release lp_mode");

        // R8 simultaneous wake and bus request
        nmi_req = 1; bus_req = 1; tick(); tick(SHORT_LEN);
        check(bus_ack, 1, "R8 bus first");
        check(core_run, 0, "R8 no wake yet");
        bus_req = 0; tick();
        check(osc_en, 0, "R8 standby between");
        tick(); nmi_req = 0;
        check(osc_en, 1, "R8 wake accepted");
        tick(SHORT_LEN - 1);
        check(core_run, 0, "R8 wake early");
        tick();
        check(core_run, 1, "R8 wake due");

        // R11 reset out of standby
        do_sleep(1, 1); tick(3);
        rst = 1; tick(); rst = 0;
        check(core_run, 1, "R11 reset wake");
        check(lp_mode, 0, "R11 reset lp_mode");
        check(div_one, 0, "R11 reset div");

        // random rounds
        for (int i = 0; i < 16; i++) begin
            logic io, sb, qk;
            int m;
            io = 1'($urandom); sb = 1'($urandom); qk = 1'($urandom);
            cfg_quick = qk;
            do_sleep(io, sb);
            m = exp_mode(io, sb);
            check(lp_mode, m, "R2/R3 random mode");
            check(osc_en, (m == 3) ? 0 : 1, "R2/R3 random osc_en");
            nmi_req = 1; tick(); nmi_req = 0;
            if (m == 3) begin
                tick(exp_len(qk) - 1);
                check(core_run, 0, "R5 random early");
                tick();
            end
            check(core_run, 1, "R5/R10 random wake");
        end
        summary();
    end
endmodule